// File: doc/BRIEF.md
# Memory-Mapped Down-Counting Interval Timer

This block is a 32-bit interval timer that sits on a simple word-wide register bus. Software programs a reload value, sets a start bit and a reload/interrupt-enable bit in the control word, and the block then counts down once per qualified tick. When the live count reaches zero, one of two things happens. With the reload bit set, the next tick loads the count from the reload register and the interrupt output is raised while the count sits at zero. With the reload bit clear, the count parks at zero.

A single control bit both enables the interrupt and enables reload at zero. Starting the timer does not preload the count, so after reset the first started tick performs the reload. The live count can only be read. The status word is plain scratch storage. Illegal accesses raise a one-cycle error pulse and change no register.

Top module: `countdown_timer`

## Requirements
- R1: After reset, all four registers read as zero, and `irq` and `bus_err` are low.
- R2: Word offsets are decoded from `bus_addr[3:2]`: 0 is status, 1 is control, 2 is the reload value and 3 is the live count. Read data appears on `bus_rdata` in the cycle after a legal read strobe, and is zero otherwise.
- R3: Legal writes to status, control and the reload register store all 32 bits, and a later read returns the stored value.
- R4: The count changes only in a cycle where `tick_en` is high and control bit 2 (start) is set.
- R5: On such a tick, a nonzero count decreases by exactly one.
- R6: On such a tick, a zero count is loaded from the reload register if control bit 0 is set, and stays zero if control bit 0 is clear.
- R7: `irq` is a register that updates in every cycle with `tick_en` high. It takes the value (count after the tick is zero AND control bit 0 is set), so it stays high while the count remains at zero.
- R8: Writing control with bit 2 set does not load the count. The count keeps its value until the first started tick.
- R9: An access is illegal if any of these holds: it is a write to offset 3; `bus_be` is not 4'hF; or any address bit other than [3:2] is set. An illegal access pulses `bus_err` in the following cycle, leaves every register unchanged, and returns zero read data.
- R10: When a bus write to control or the reload register falls in the same cycle as a tick, that tick uses the previous values. The write takes effect from the next tick onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count qualifier, one tick per high cycle |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte enables, must be all ones |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| bus_err | output | 1 | One-cycle illegal-access pulse |
| irq | output | 1 | Interrupt level |

## Verification
The hardest situations to reach are the ones where a bus write and a tick share a cycle: a reload-register write at the exact tick that reloads from zero, and a stop written on the tick that still decrements. The bench reaches them by holding `tick_en` low while it parks the count at a known value through counted tick bursts. It then raises `tick_en` in the same cycle as the write strobe. The reload-at-zero after start is reached the same way, by reading the count back between bursts.

// File: rtl/countdown_timer.sv
module countdown_timer #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  output logic              irq
);
  localparam int RELOAD_BIT = 0;
  localparam int START_BIT  = 2;
  localparam logic [1:0] OFS_STAT = 2'd0;
  localparam logic [1:0] OFS_CTRL = 2'd1;
  localparam logic [1:0] OFS_RLD  = 2'd2;
  localparam logic [1:0] OFS_CNT  = 2'd3;

  logic [DATA_W-1:0] status_q, ctrl_q, period_q, cnt_q, cnt_nxt;
  logic [1:0] sel;
  logic access, map_ok, bad, wr_ok, rd_ok, tick_go;

  assign sel     = bus_addr[3:2];
  assign access  = bus_wr | bus_rd;
  assign map_ok  = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:4] == '0);
  assign bad     = access && (!(&bus_be) || !map_ok || (bus_wr && sel == OFS_CNT));
  assign wr_ok   = bus_wr && !bad;
  assign rd_ok   = bus_rd && !bad;
  assign tick_go = tick_en && ctrl_q[START_BIT];

  always_comb begin
    cnt_nxt = cnt_q;
    if (tick_go) begin
      if (cnt_q != '0)
        cnt_nxt = cnt_q - 1'b1;
      else if (ctrl_q[RELOAD_BIT])
        cnt_nxt = period_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      ctrl_q   <= '0;
      period_q <= '0;
    end else if (wr_ok) begin
      case (sel)
        OFS_STAT: status_q <= bus_wdata[DATA_W-1:0];
        OFS_CTRL: ctrl_q   <= bus_wdata[DATA_W-1:0];
        OFS_RLD:  period_q <= bus_wdata[DATA_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq   <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (tick_en)
        irq <= (cnt_nxt == '0) && ctrl_q[RELOAD_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_err <= bad;
      if (rd_ok) begin
        case (sel)
          OFS_STAT: bus_rdata <= status_q;
          OFS_CTRL: bus_rdata <= ctrl_q;
          OFS_RLD:  bus_rdata <= period_q;
          default:  bus_rdata <= cnt_q;
        endcase
      end else begin
        bus_rdata <= '0;
      end
    end
  end
endmodule

module countdown_timer_props #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_be,
  input logic              bus_err,
  input logic              irq,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] period_q,
  input logic [DATA_W-1:0] status_q
);
  logic illegal;
  assign illegal = (bus_wr || bus_rd) &&
                   (bus_be != 4'hF || bus_addr[1:0] != 2'b00 || bus_addr[ADDR_W-1:4] != '0 ||
                    (bus_wr && bus_addr[3:2] == 2'd3));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_en && ctrl_q[2]) |=> $stable(cnt_q));
  a_r5_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && ctrl_q[2] && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && ctrl_q[2] && cnt_q == '0 && ctrl_q[0]) |=> cnt_q == $past(period_q));
  a_r7_irq: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> irq == (cnt_q == '0 && $past(ctrl_q[0])));
  a_r9_err: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> bus_err);
  a_r9_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal && !bus_rd) |=> ($stable(ctrl_q) && $stable(period_q) && $stable(status_q)));
endmodule

bind countdown_timer countdown_timer_props #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_props (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_be(bus_be), .bus_err(bus_err), .irq(irq),
  .cnt_q(cnt_q), .ctrl_q(ctrl_q), .period_q(period_q), .status_q(status_q)
);

// File: tb/sim_countdown_timer.sv
module sim_countdown_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [3:0] bus_be = 4'hF;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_err, irq;
  int checks = 0, errors = 0;

  typedef struct {
    bit          is_rd;
    logic [31:0] data;
    bit          err;
    string       tag;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  countdown_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .irq(irq)
  );

  always @(posedge clk) begin
    if (rst_n && (bus_rd || bus_wr)) begin
      item_t it;
      #2;
      if (sb.size() == 0) begin
        errors++; checks++;
        $display("FAIL scoreboard empty: actual access seen, expected none");
      end else begin
        it = sb.pop_front();
        checks++;
        if (bus_err !== it.err) begin
          errors++;
          $display("FAIL %s err actual %0b expected %0b", it.tag, bus_err, it.err);
        end
        if (it.is_rd) begin
          checks++;
          if (bus_rdata !== it.data) begin
            errors++;
            $display("FAIL %s rdata actual %h expected %h", it.tag, bus_rdata, it.data);
          end
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be,
                    input bit e, input bit tk, input string tag);
    item_t it;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be; tick_en = tk;
    it.is_rd = 0; it.data = '0; it.err = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    bus_wr = 1'b0; tick_en = 1'b0; bus_be = 4'hF;
  endtask

  task automatic rd(input logic [7:0] a, input logic [3:0] be, input logic [31:0] exp,
                    input bit e, input string tag);
    item_t it;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_be = be;
    it.is_rd = 1; it.data = exp; it.err = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    bus_rd = 1'b0; bus_be = 4'hF;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic chk_irq(input bit exp, input string tag);
    @(negedge clk);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq actual %0b expected %0b", tag, irq, exp);
    end
  endtask

  initial begin
    #(8 * 50000);
    errors++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values, R2 offsets
    chk_irq(0, "R1");
    rd(8'h00, 4'hF, 32'h0, 0, "R1 status");
    rd(8'h04, 4'hF, 32'h0, 0, "R1 control");
    rd(8'h08, 4'hF, 32'h0, 0, "R1 period");
    rd(8'h0C, 4'hF, 32'h0, 0, "R2 count");
    // R3 read/write storage
    wr(8'h00, 32'hA5A5_1234, 4'hF, 0, 0, "R3 status");
    wr(8'h08, 32'd5, 4'hF, 0, 0, "R3 period");
    rd(8'h00, 4'hF, 32'hA5A5_1234, 0, "R3 status");
    rd(8'h08, 4'hF, 32'd5, 0, "R3 period");
    // R6 no reload when bit0 clear
    wr(8'h04, 32'h4, 4'hF, 0, 0, "R3 control");
    ticks(3);
    rd(8'h0C, 4'hF, 32'h0, 0, "R6 stays zero");
    chk_irq(0, "R7 no irq without bit0");
    // R8 start does not preload
    wr(8'h04, 32'h5, 4'hF, 0, 0, "R8 start");
    rd(8'h0C, 4'hF, 32'h0, 0, "R8 no preload");
    ticks(1);
    rd(8'h0C, 4'hF, 32'd5, 0, "R6 reload");
    chk_irq(0, "R7 after reload");
    ticks(2);
    rd(8'h0C, 4'hF, 32'd3, 0, "R5 decrement");
    // R4 stopped: no change even with tick_en
    wr(8'h04, 32'h1, 4'hF, 0, 0, "R4 stop");
    ticks(4);
    rd(8'h0C, 4'hF, 32'd3, 0, "R4 hold");
    wr(8'h04, 32'h5, 4'hF, 0, 0, "R4 restart");
    ticks(3);
    chk_irq(1, "R7 at zero");
    rd(8'h0C, 4'hF, 32'd0, 0, "R5 to zero");
    wr(8'h04, 32'h1, 4'hF, 0, 0, "R7 stop at zero");
    ticks(2);
    chk_irq(1, "R7 holds at zero");
    rd(8'h0C, 4'hF, 32'd0, 0, "R4 zero held");
    // R9 illegal accesses
    wr(8'h0C, 32'h77, 4'hF, 1, 0, "R9 write count");
    rd(8'h0C, 4'hF, 32'd0, 0, "R9 count unchanged");
    wr(8'h04, 32'h0, 4'h3, 1, 0, "R9 partial write");
    rd(8'h04, 4'hF, 32'h1, 0, "R9 control unchanged");
    wr(8'h0A, 32'h99, 4'hF, 1, 0, "R9 misaligned write");
    wr(8'h48, 32'h99, 4'hF, 1, 0, "R9 unmapped write");
    rd(8'h08, 4'hF, 32'd5, 0, "R9 period unchanged");
    rd(8'h44, 4'hF, 32'h0, 1, "R9 unmapped read");
    rd(8'h00, 4'h1, 32'h0, 1, "R9 partial read");
    // R10 coincident writes use old values
    wr(8'h04, 32'h5, 4'hF, 0, 0, "R10 setup");
    wr(8'h08, 32'd9, 4'hF, 0, 1, "R10 period+tick");
    rd(8'h0C, 4'hF, 32'd5, 0, "R10 old period used");
    wr(8'h04, 32'h0, 4'hF, 0, 1, "R10 stop+tick");
    rd(8'h0C, 4'hF, 32'd4, 0, "R10 last tick counted");
    ticks(3);
    rd(8'h0C, 4'hF, 32'd4, 0, "R10 stop effective");
    rd(8'h08, 4'hF, 32'd9, 0, "R10 period written");
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard actual %0d left expected 0", sb.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule